// File: doc/BRIEF.md
# Pointer Cursor Overlay

This block lays a 16x16 pointer cursor over a stream of pixel colour indices. The display pipeline feeds it, one pixel per clock, the raster coordinates, a valid flag for the active area and the background colour index. The background can come from any text or graphics mode. Two clocks later the block returns the final colour index. The cursor shape is kept in two bitplanes of 16 rows by 16 bits. Together the two bits of each cursor pixel choose one of four behaviours: leave the background alone, complement it, or replace it with one of two colour indices set aside for the cursor in the palette.

Software reaches the block through a simple register write port. It uses this port to load shape rows, set the cursor position and turn the cursor on or off. Shape rows take effect as soon as they are written. Position and enable writes go to shadow registers, which are copied into the active set when vertical blanking begins, so the cursor never tears mid-frame. A cursor that hangs past the right or bottom edge of the active area is clipped, and its coordinates never wrap around to the opposite edge.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, out_valid and out_idx are 0, and the active cursor is disabled at position (0,0).
- R2: A cursor pixel with plane code 00 (plane 1 bit is the high bit, plane 0 bit is the low bit) outputs the background index unchanged.
- R3: A cursor pixel with plane code 01 outputs the bitwise complement of the background index.
- R4: Plane code 10 outputs CUR_COLOR0 and plane code 11 outputs CUR_COLOR1, whatever the background is.
- R5: A valid pixel outside the cursor window outputs the background index.
- R6: While the active enable is 0, every valid pixel outputs the background index.
- R7: Writes to X (address 0x20, data bits 9:0), Y (address 0x21, data bits 9:0) and enable (address 0x22, data bit 0) change the displayed cursor only after the next rising edge of vblank.
- R8: The window covers x from CX to CX+15 and y from CY to CY+15. Window row r is the word at address 0x00+r (plane 0) or 0x10+r (plane 1), and window column c is bit 15-c of that word. A shape write is visible from the next pixel that reads that row.
- R9: When the cursor extends past the right or bottom edge of the active area, the overhanging pixels are dropped. A position near 1023 does not wrap onto low coordinates. Pixels with pix_valid low produce out_valid 0 and out_idx 0.
- R10: out_valid and out_idx reflect the pixel presented two clocks earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Write address: shape rows 0x00-0x1F, controls 0x20-0x22 |
| reg_wdata | input | 16 | Write data |
| vblank | input | 1 | Vertical blanking flag; its rising edge loads position and enable |
| pix_valid | input | 1 | Pixel is inside the active area |
| pix_x | input | 10 | Pixel column |
| pix_y | input | 10 | Pixel row |
| bg_idx | input | 8 | Background colour index |
| out_valid | output | 1 | Output pixel valid |
| out_idx | output | 8 | Composited colour index |

## Verification
Some properties hold on every cycle, and the assertions check those. Output validity tracks the input flag two clocks later, and an idle output is zero. A disabled cursor passes the background through unchanged. A composited index is always the background, its complement or one of the two cursor colours. The active position and enable change only on a rising edge of vblank. Other behaviours need the bench's scenarios and its per-clock reference model. These are the choice of behaviour for each plane code, the mapping from rows and bit columns to the screen, clipping at the right and bottom edges, the absence of wrap-around near coordinate 1023, and the fact that a shape row rewritten mid-frame takes effect at once.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  // Two-bit cursor pixel code: {plane1 bit, plane0 bit}
  typedef enum logic [1:0] {
    PX_CLEAR  = 2'b00,
    PX_INVERT = 2'b01,
    PX_COL0   = 2'b10,
    PX_COL1   = 2'b11
  } px_code_t;

  localparam int CTL_SEL_X  = 0;
  localparam int CTL_SEL_Y  = 1;
  localparam int CTL_SEL_EN = 2;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs import cursor_pkg::*; #(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_sel,
  input  logic [POS_W-1:0] ctl_data,
  input  logic             vblank,
  output logic [POS_W-1:0] act_x,
  output logic [POS_W-1:0] act_y,
  output logic             act_en
);
  logic [POS_W-1:0] sh_x, sh_y;
  logic             sh_en;
  logic             vb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_x   <= '0;
      sh_y   <= '0;
      sh_en  <= 1'b0;
      act_x  <= '0;
      act_y  <= '0;
      act_en <= 1'b0;
      vb_q   <= 1'b0;
    end else begin
      vb_q <= vblank;
      if (vblank && !vb_q) begin
        act_x  <= sh_x;
        act_y  <= sh_y;
        act_en <= sh_en;
      end
      if (ctl_wr) begin
        case (ctl_sel)
          2'(CTL_SEL_X):  sh_x  <= ctl_data;
          2'(CTL_SEL_Y):  sh_y  <= ctl_data;
          2'(CTL_SEL_EN): sh_en <= ctl_data[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cursor_plane_ram.sv
module cursor_plane_ram #(
  parameter int SIZE  = 16,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] waddr,
  input  logic [SIZE-1:0]  wdata,
  input  logic [ROW_W-1:0] raddr,
  output logic [SIZE-1:0]  rdata
);
  logic [SIZE-1:0] mem [SIZE];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cursor_window.sv
module cursor_window #(
  parameter int POS_W = 10,
  parameter int SIZE  = 16,
  localparam int ROW_W = $clog2(SIZE)
) (
  input  logic             en,
  input  logic             pix_valid,
  input  logic [POS_W-1:0] pix_x,
  input  logic [POS_W-1:0] pix_y,
  input  logic [POS_W-1:0] cx,
  input  logic [POS_W-1:0] cy,
  output logic             hit,
  output logic [ROW_W-1:0] row,
  output logic [ROW_W-1:0] col
);
  logic [POS_W:0] dx, dy;
  logic           in_x, in_y;

  always_comb begin
    dx   = {1'b0, pix_x} - {1'b0, cx};
    dy   = {1'b0, pix_y} - {1'b0, cy};
    in_x = (pix_x >= cx) && (dx < (POS_W+1)'(SIZE));
    in_y = (pix_y >= cy) && (dy < (POS_W+1)'(SIZE));
    hit  = en && pix_valid && in_x && in_y;
    row  = dy[ROW_W-1:0];
    col  = dx[ROW_W-1:0];
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay import cursor_pkg::*; #(
  parameter int POS_W   = 10,
  parameter int SIZE    = 16,
  parameter int COLOR_W = 8,
  parameter logic [COLOR_W-1:0] CUR_COLOR0 = 8'hF0,
  parameter logic [COLOR_W-1:0] CUR_COLOR1 = 8'hF1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic [$clog2(SIZE)+1:0]  reg_addr,
  input  logic [SIZE-1:0]          reg_wdata,
  input  logic                     vblank,
  input  logic                     pix_valid,
  input  logic [POS_W-1:0]         pix_x,
  input  logic [POS_W-1:0]         pix_y,
  input  logic [COLOR_W-1:0]       bg_idx,
  output logic                     out_valid,
  output logic [COLOR_W-1:0]       out_idx
);
  localparam int ROW_W  = $clog2(SIZE);
  localparam int ADDR_W = ROW_W + 2;

  logic [POS_W-1:0] act_x, act_y;
  logic             act_en;
  logic             win_hit;
  logic [ROW_W-1:0] win_row, win_col;
  logic [SIZE-1:0]  plane_row [2];

  // stage 1 registers
  logic               s1_valid, s1_hit;
  logic [ROW_W-1:0]   s1_col;
  logic [COLOR_W-1:0] s1_bg;

  logic [ROW_W-1:0]   bitpos;
  px_code_t           code;

  cursor_regs #(.POS_W(POS_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .ctl_wr  (reg_wr && reg_addr[ADDR_W-1]),
    .ctl_sel (reg_addr[1:0]),
    .ctl_data(reg_wdata[POS_W-1:0]),
    .vblank  (vblank),
    .act_x   (act_x),
    .act_y   (act_y),
    .act_en  (act_en)
  );

  cursor_window #(.POS_W(POS_W), .SIZE(SIZE)) u_win (
    .en       (act_en),
    .pix_valid(pix_valid),
    .pix_x    (pix_x),
    .pix_y    (pix_y),
    .cx       (act_x),
    .cy       (act_y),
    .hit      (win_hit),
    .row      (win_row),
    .col      (win_col)
  );

  for (genvar p = 0; p < 2; p++) begin : g_plane
    cursor_plane_ram #(.SIZE(SIZE), .ROW_W(ROW_W)) u_ram (
      .clk  (clk),
      .we   (reg_wr && !reg_addr[ADDR_W-1] && (reg_addr[ROW_W] == 1'(p))),
      .waddr(reg_addr[ROW_W-1:0]),
      .wdata(reg_wdata),
      .raddr(win_row),
      .rdata(plane_row[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_col   <= '0;
      s1_bg    <= '0;
    end else begin
      s1_valid <= pix_valid;
      s1_hit   <= win_hit;
      s1_col   <= win_col;
      s1_bg    <= bg_idx;
    end
  end

  always_comb begin
    bitpos = ROW_W'(SIZE-1) - s1_col;
    code   = px_code_t'({plane_row[1][bitpos], plane_row[0][bitpos]});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (!s1_valid)    out_idx <= '0;
      else if (!s1_hit) out_idx <= s1_bg;
      else begin
        case (code)
          PX_CLEAR:  out_idx <= s1_bg;
          PX_INVERT: out_idx <= ~s1_bg;
          PX_COL0:   out_idx <= CUR_COLOR0;
          default:   out_idx <= CUR_COLOR1;
        endcase
      end
    end
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int POS_W   = 10,
  parameter int COLOR_W = 8,
  parameter logic [COLOR_W-1:0] CUR_COLOR0 = 8'hF0,
  parameter logic [COLOR_W-1:0] CUR_COLOR1 = 8'hF1
) (
  input logic               clk,
  input logic               rst,
  input logic               vblank,
  input logic               pix_valid,
  input logic [COLOR_W-1:0] bg_idx,
  input logic               out_valid,
  input logic [COLOR_W-1:0] out_idx,
  input logic [POS_W-1:0]   act_x,
  input logic [POS_W-1:0]   act_y,
  input logic               act_en
);
  logic [1:0] cyc;
  logic       vb_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc     <= '0;
      vb_prev <= 1'b0;
    end else begin
      if (cyc != 2'd2) cyc <= cyc + 2'd1;
      vb_prev <= vblank;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd2) |-> (out_valid == $past(pix_valid, 2))); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_idx == '0)); // R9

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (rst)
    ((cyc == 2'd2) && $past(pix_valid, 2) && !$past(act_en, 2))
      |-> (out_idx == $past(bg_idx, 2))); // R6

  AST_INDEX_CHOICES: assert property (@(posedge clk) disable iff (rst)
    ((cyc == 2'd2) && out_valid) |->
      (out_idx == $past(bg_idx, 2) || out_idx == ~$past(bg_idx, 2) ||
       out_idx == CUR_COLOR0 || out_idx == CUR_COLOR1)); // R4

  AST_LATCH_AT_VBLANK: assert property (@(posedge clk) disable iff (rst)
    ((cyc != 2'd0) && !(vblank && !vb_prev))
      |=> ($stable(act_x) && $stable(act_y) && $stable(act_en))); // R7
endmodule

bind cursor_overlay cursor_overlay_chk #(
  .POS_W(POS_W), .COLOR_W(COLOR_W),
  .CUR_COLOR0(CUR_COLOR0), .CUR_COLOR1(CUR_COLOR1)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .vblank   (vblank),
  .pix_valid(pix_valid),
  .bg_idx   (bg_idx),
  .out_valid(out_valid),
  .out_idx  (out_idx),
  .act_x    (act_x),
  .act_y    (act_y),
  .act_en   (act_en)
);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  localparam int HTOT = 48, HACT = 40, VTOT = 34, VACT = 30;
  localparam logic [7:0] C0 = 8'hF0, C1 = 8'hF1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic       vblank, pix_valid;
  logic [9:0] pix_x, pix_y;
  logic [7:0] bg_idx;
  logic       out_valid;
  logic [7:0] out_idx;

  int hc = 0, vc = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  cursor_overlay dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .vblank(vblank), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .bg_idx(bg_idx),
    .out_valid(out_valid), .out_idx(out_idx)
  );

  // raster generator
  always @(posedge clk) begin
    if (rst) begin hc <= 0; vc <= 0; end
    else if (hc == HTOT-1) begin hc <= 0; vc <= (vc == VTOT-1) ? 0 : vc + 1; end
    else hc <= hc + 1;
  end
  assign pix_valid = (hc < HACT) && (vc < VACT);
  assign vblank    = (vc >= VACT);
  assign pix_x     = 10'(hc);
  assign pix_y     = 10'(vc);
  assign bg_idx    = 8'((hc * 5 + vc * 11) ^ 8'h5A);

  // reference model
  int sx, sy, ax, ay;
  bit sen, aen, vbp;
  logic [15:0] p0 [16];
  logic [15:0] p1 [16];
  bit s1v, expv;
  logic [7:0] s1i, expi;
  string s1tag, exptag;

  initial for (int i = 0; i < 16; i++) begin p0[i] = '0; p1[i] = '0; end

  always @(posedge clk) begin
    if (rst) begin
      sx = 0; sy = 0; ax = 0; ay = 0; sen = 0; aen = 0; vbp = 0;
      s1v = 0; s1i = 0; s1tag = "R1"; expv = 0; expi = 0; exptag = "R1";
    end else begin
      expv = s1v; expi = s1i; exptag = s1tag;
      begin
        int x, y, r, c;
        bit pend;
        x = int'(pix_x); y = int'(pix_y);
        pend = (sx != ax) || (sy != ay) || (sen != aen);
        if (!pix_valid) begin
          s1v = 0; s1i = 0; s1tag = "R9";
        end else begin
          s1v = 1;
          if (!aen) begin s1i = bg_idx; s1tag = "R6"; end
          else if (x < ax || x >= ax + 16 || y < ay || y >= ay + 16) begin
            s1i = bg_idx; s1tag = "R5/R9";
          end else begin
            r = y - ay; c = x - ax;
            case ({p1[r][15-c], p0[r][15-c]})
              2'b00: begin s1i = bg_idx;  s1tag = "R2/R8"; end
              2'b01: begin s1i = ~bg_idx; s1tag = "R3/R8"; end
              2'b10: begin s1i = C0;      s1tag = "R4/R8"; end
              default: begin s1i = C1;    s1tag = "R4/R8"; end
            endcase
          end
        end
        s1tag = {s1tag, "/R10", pend ? "/R7" : ""};
      end
      if (vblank && !vbp) begin ax = sx; ay = sy; aen = sen; end
      vbp = vblank;
      if (reg_wr) begin
        if (reg_addr[5]) begin
          case (reg_addr[1:0])
            2'd0: sx = int'(reg_wdata[9:0]);
            2'd1: sy = int'(reg_wdata[9:0]);
            2'd2: sen = reg_wdata[0];
            default: ;
          endcase
        end else if (reg_addr[4]) p1[reg_addr[3:0]] = reg_wdata;
        else p0[reg_addr[3:0]] = reg_wdata;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== expv || out_idx !== expi) begin
        fails++;
        $display("FAIL %s at x=%0d y=%0d: actual valid=%0b idx=%h expected valid=%0b idx=%h",
                 exptag, hc, vc, out_valid, out_idx, expv, expi);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_line(input int n);
    do @(negedge clk); while (!(hc == 0 && vc == n));
  endtask

  task automatic set_cursor(input int x, input int y, input bit en);
    wr(6'h20, 16'(x)); wr(6'h21, 16'(y)); wr(6'h22, 16'(en));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state visible at the ports
    checks++;
    if (out_valid !== 1'b0 || out_idx !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset: actual valid=%0b idx=%h expected valid=0 idx=00", out_valid, out_idx);
    end
    rst = 1'b0;
    // load shape, mixing all four codes (R2 R3 R4 R8)
    for (int r = 0; r < 16; r++) begin
      wr(6'(r),      16'hF0F0 ^ 16'(r * 16'h0123));
      wr(6'(16 + r), 16'hCC33 ^ 16'(r * 16'h0421));
    end
    set_cursor(5, 3, 1);
    wait_line(0); wait_line(20);
    // R7: move mid-frame, must hold until vblank
    set_cursor(20, 12, 1);
    wait_line(0); wait_line(20);
    // R8: rewrite a shape row while displayed
    wr(6'h04, 16'h8001); wr(6'h14, 16'hC003);
    wait_line(0);
    // R9: clip at right and bottom edges
    set_cursor(32, 22, 1);
    wait_line(0); wait_line(0);
    // R8: right-most column exactly on the last active pixel
    set_cursor(24, 0, 1);
    wait_line(0); wait_line(0);
    // R9: no wrap-around near 1023
    set_cursor(1020, 2, 1);
    wait_line(0); wait_line(0);
    set_cursor(3, 1020, 1);
    wait_line(0); wait_line(0);
    // R6: disabled cursor
    set_cursor(5, 3, 0);
    wait_line(0); wait_line(0);
    // re-enable at origin
    set_cursor(0, 0, 1);
    wait_line(0); wait_line(0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule